// File: doc/BRIEF.md
# Three-Phase Capture/Compare PWM Unit

This block is a motor-control timer. A 16-bit main timer serves three channels. Each channel runs either as a comparator or as a capture latch. In compare mode a channel drives a complementary high-side/low-side pair with a programmable dead gap, so both switches of a half-bridge are never on at once. In capture mode the channel stores the main-timer count when its capture pin changes level. A second, independent 10-bit timer has one comparator. It produces an extra PWM output, and it can be switched in to gate all six channel outputs. A trap input forces every output low at once.

Software reaches the block through a small register port. The timers cannot be written directly. Writing an offset register places a start value in a timer and copies the buffered period and compare values into their working copies. Otherwise those buffered values take effect only when the timer wraps. Both timers step on a shared prescaled tick and each has its own run bit.

Address map, 4-bit address. 0 is the control word: bit 0 runs the main timer, bit 1 runs the aux timer, bits 3:2 set the prescale code, and bit 4 enables gating by the aux PWM. 1 holds the mode bits, bit i = 1 for capture on channel i. 2 holds the dead time. 3 is the main period and 4 the main offset. 5, 6 and 7 are the compares of channels 0 to 2. 8 is the aux period, 9 the aux offset and 10 the aux compare. 12, 13 and 14 read the captures of channels 0 to 2.

Each channel runs a state machine with five states:
- OFF: the channel is in capture mode or has just left reset. Both outputs are low.
- WAIT_HI and WAIT_LO: a dead-time countdown is running before the named side switches on. Both outputs are low.
- HI: the high-side output is on.
- LO: the low-side output is on.

The transitions are:
- OFF to WAIT_HI or WAIT_LO happens when compare mode is selected. The target follows the raw compare level, and the countdown is loaded with the dead time.
- WAIT_HI to HI and WAIT_LO to LO happen when the countdown is already zero.
- WAIT_HI and WAIT_LO cross to each other when the raw level flips, and the countdown is reloaded.
- HI to WAIT_LO and LO to WAIT_HI happen when the raw level flips, and the countdown is loaded.
- Any state goes to OFF when capture mode is selected.

Top module: `pwm3_capcmp`

## Requirements
- R1: While reset is active and just after it, all seven outputs are low and the capture registers read 0. The main period reads 0xFFFF and the dead time reads 0.
- R2: A value written to a register address reads back unchanged on the same address. The aux registers keep their low 10 bits.
- R3: Each timer counts from 0 up to its period, then returns to 0. It steps once every 1, 2, 4 or 8 clocks for prescale codes 0, 1, 2 or 3. One output cycle therefore lasts D*(P+1) clocks.
- R4: A channel's raw level is high while count < compare. With dead time d and steady inputs, the high side is on for D*C-(d+1) clocks per cycle and the low side for D*(P+1-C)-(d+1). If C = 0 the high side is never on. If C > P it is always on.
- R5: The two outputs of a pair are never high together. Every hand-over leaves both low for exactly d+1 clocks.
- R6: Period and compare writes take effect only at a timer wrap or an offset write. With the run bit clear the timer holds its count.
- R7: Writing an offset address loads that value into the timer at once.
- R8: In capture mode, either edge on a channel's capture pin stores the main count into that channel's capture register after a two-flop synchroniser. In compare mode the pin has no effect.
- R9: A channel in capture mode holds both of its outputs low.
- R10: The aux output is high for D*min(A, Pa+1) clocks of every D*(Pa+1)-clock aux cycle, where A is the aux compare and Pa the aux period.
- R11: With control bit 4 set, every channel output is ANDed with the aux output.
- R12: While the trap input is high, all seven outputs are low in the same cycle. They stay low after the trap clears until the main timer next wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational |
| cap_in | input | 3 | Capture pins, one per channel |
| trap_in | input | 1 | Trap request, forces outputs low |
| pwm_hi | output | 3 | High-side outputs |
| pwm_lo | output | 3 | Low-side outputs |
| aux_pwm | output | 1 | PWM from the 10-bit timer |

## Verification
A corrupt dead-time counter or a wrong channel state shows up within one PWM cycle. The measured on-times and gap lengths drift from D*C-(d+1) and d+1, or the two outputs of a pair overlap in the same clock. A working compare or period copied at the wrong moment shows up at once while the timer is halted: the outputs change with no wrap or offset write. A stale trap latch or a bad synchroniser shows up within a single main-timer cycle, or as a capture value that differs from the loaded count.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 4'd1;
    localparam logic [ADDR_W-1:0] A_DEAD = 4'd2;
    localparam logic [ADDR_W-1:0] A_MPER = 4'd3;
    localparam logic [ADDR_W-1:0] A_MOFS = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMP0 = 4'd5;
    localparam logic [ADDR_W-1:0] A_APER = 4'd8;
    localparam logic [ADDR_W-1:0] A_AOFS = 4'd9;
    localparam logic [ADDR_W-1:0] A_ACMP = 4'd10;
    localparam logic [ADDR_W-1:0] A_CAP0 = 4'd12;

    // control word fields
    localparam int C_MRUN = 0;
    localparam int C_ARUN = 1;
    localparam int C_PS_LO = 2;
    localparam int C_MOD = 4;
    localparam int CTRL_W = 5;

    typedef enum logic [2:0] {
        CH_OFF,
        CH_WAIT_HI,
        CH_HI,
        CH_WAIT_LO,
        CH_LO
    } ch_state_e;
endpackage

// File: rtl/pwm3_presc.sv
module pwm3_presc #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (!rst_n) pcnt <= '0;
        else        pcnt <= pcnt + 1'b1;
    end

    always_comb begin
        mask = ~({CNT_W{1'b1}} << sel);
        tick = ((pcnt & mask) == mask);
    end
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] per_sh,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] per_act;

    assign wrap = run && tick && !load && (cnt >= per_act);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            per_act <= '1;
        end else if (load) begin
            cnt     <= load_val;
            per_act <= per_sh;
        end else if (run && tick) begin
            if (cnt >= per_act) begin
                cnt     <= '0;
                per_act <= per_sh;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm3_chan.sv
module pwm3_chan
    import pwm3_pkg::*;
#(
    parameter int CW   = 16,
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_mode,
    input  logic            raw,
    input  logic [DT_W-1:0] dead,
    input  logic            cap_in,
    input  logic [CW-1:0]   cnt,
    output logic            hi,
    output logic            lo,
    output logic [CW-1:0]   cap_val,
    output logic            cap_fire
);
    ch_state_e       st, st_nxt;
    logic [DT_W-1:0] dt_q, dt_nxt;
    logic [2:0]      sync_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= CH_OFF;
            dt_q <= '0;
        end else begin
            st   <= st_nxt;
            dt_q <= dt_nxt;
        end
    end

    // transitions
    always_comb begin
        st_nxt = st;
        dt_nxt = dt_q;
        unique case (st)
            CH_OFF: if (!cap_mode) begin
                st_nxt = raw ? CH_WAIT_HI : CH_WAIT_LO;
                dt_nxt = dead;
            end
            CH_WAIT_HI: begin
                if (cap_mode)        st_nxt = CH_OFF;
                else if (!raw) begin st_nxt = CH_WAIT_LO; dt_nxt = dead; end
                else if (dt_q == '0) st_nxt = CH_HI;
                else                 dt_nxt = dt_q - 1'b1;
            end
            CH_HI: begin
                if (cap_mode)        st_nxt = CH_OFF;
                else if (!raw) begin st_nxt = CH_WAIT_LO; dt_nxt = dead; end
            end
            CH_WAIT_LO: begin
                if (cap_mode)        st_nxt = CH_OFF;
                else if (raw)  begin st_nxt = CH_WAIT_HI; dt_nxt = dead; end
                else if (dt_q == '0) st_nxt = CH_LO;
                else                 dt_nxt = dt_q - 1'b1;
            end
            CH_LO: begin
                if (cap_mode)        st_nxt = CH_OFF;
                else if (raw)  begin st_nxt = CH_WAIT_HI; dt_nxt = dead; end
            end
            default: st_nxt = CH_OFF;
        endcase
    end

    // outputs
    always_comb begin
        hi = (st == CH_HI);
        lo = (st == CH_LO);
    end

    // capture path: two sync flops plus one for edge detection
    assign cap_fire = cap_mode && (sync_q[1] ^ sync_q[2]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= '0;
            cap_val <= '0;
        end else begin
            sync_q <= {sync_q[1:0], cap_in};
            if (cap_fire) cap_val <= cnt;
        end
    end
endmodule

// File: rtl/pwm3_capcmp.sv
module pwm3_capcmp
    import pwm3_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int MAIN_W = 16,
    parameter int AUX_W  = 10,
    parameter int DT_W   = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NCH-1:0]    cap_in,
    input  logic              trap_in,
    output logic [NCH-1:0]    pwm_hi,
    output logic [NCH-1:0]    pwm_lo,
    output logic              aux_pwm
);
    logic [CTRL_W-1:0]            ctrl_q;
    logic [NCH-1:0]               mode_q;
    logic [DT_W-1:0]              dead_q;
    logic [MAIN_W-1:0]            mper_q, mofs_q;
    logic [AUX_W-1:0]             aper_q, aofs_q, acmp_q, acmp_act;
    logic [NCH-1:0][MAIN_W-1:0]   cmp_sh, cmp_act, cap_val;
    logic [NCH-1:0]               cap_fire, ch_hi, ch_lo;
    logic [MAIN_W-1:0]            main_cnt;
    logic [AUX_W-1:0]             aux_cnt;
    logic                         tick, main_wrap, aux_wrap, main_load, aux_load;
    logic                         aux_q, trap_hold, gate, mod_ok;

    assign main_load = wr_en && (wr_addr == A_MOFS);
    assign aux_load  = wr_en && (wr_addr == A_AOFS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            dead_q <= '0;
            mper_q <= '1;
            mofs_q <= '0;
            aper_q <= '1;
            aofs_q <= '0;
            acmp_q <= '0;
            cmp_sh <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: ctrl_q <= wr_data[CTRL_W-1:0];
                A_MODE: mode_q <= wr_data[NCH-1:0];
                A_DEAD: dead_q <= wr_data[DT_W-1:0];
                A_MPER: mper_q <= wr_data[MAIN_W-1:0];
                A_MOFS: mofs_q <= wr_data[MAIN_W-1:0];
                A_APER: aper_q <= wr_data[AUX_W-1:0];
                A_AOFS: aofs_q <= wr_data[AUX_W-1:0];
                A_ACMP: acmp_q <= wr_data[AUX_W-1:0];
                default: ;
            endcase
            for (int i = 0; i < NCH; i++)
                if (wr_addr == A_CMP0 + ADDR_W'(i)) cmp_sh[i] <= wr_data[MAIN_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: rd_data = DATA_W'(ctrl_q);
            A_MODE: rd_data = DATA_W'(mode_q);
            A_DEAD: rd_data = DATA_W'(dead_q);
            A_MPER: rd_data = DATA_W'(mper_q);
            A_MOFS: rd_data = DATA_W'(mofs_q);
            A_APER: rd_data = DATA_W'(aper_q);
            A_AOFS: rd_data = DATA_W'(aofs_q);
            A_ACMP: rd_data = DATA_W'(acmp_q);
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == A_CMP0 + ADDR_W'(i)) rd_data = DATA_W'(cmp_sh[i]);
            if (rd_addr == A_CAP0 + ADDR_W'(i)) rd_data = DATA_W'(cap_val[i]);
        end
    end

    pwm3_presc #(.SEL_W(2)) u_presc (
        .clk(clk), .rst_n(rst_n), .sel(ctrl_q[C_PS_LO +: 2]), .tick(tick)
    );

    pwm3_timer #(.W(MAIN_W)) u_main (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q[C_MRUN]),
        .load(main_load), .load_val(wr_data[MAIN_W-1:0]), .per_sh(mper_q),
        .cnt(main_cnt), .wrap(main_wrap)
    );

    pwm3_timer #(.W(AUX_W)) u_aux (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q[C_ARUN]),
        .load(aux_load), .load_val(wr_data[AUX_W-1:0]), .per_sh(aper_q),
        .cnt(aux_cnt), .wrap(aux_wrap)
    );

    // working compare copies, refreshed at wrap or offset load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_act  <= '0;
            acmp_act <= '0;
            aux_q    <= 1'b0;
            trap_hold <= 1'b0;
        end else begin
            if (main_wrap || main_load) cmp_act  <= cmp_sh;
            if (aux_wrap || aux_load)   acmp_act <= acmp_q;
            aux_q <= (aux_cnt < acmp_act);
            if (trap_in)        trap_hold <= 1'b1;
            else if (main_wrap) trap_hold <= 1'b0;
        end
    end

    assign gate   = !(trap_in || trap_hold);
    assign mod_ok = !ctrl_q[C_MOD] || aux_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm3_chan #(.CW(MAIN_W), .DT_W(DT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .cap_mode(mode_q[g]),
            .raw(main_cnt < cmp_act[g]), .dead(dead_q), .cap_in(cap_in[g]),
            .cnt(main_cnt), .hi(ch_hi[g]), .lo(ch_lo[g]),
            .cap_val(cap_val[g]), .cap_fire(cap_fire[g])
        );
        assign pwm_hi[g] = ch_hi[g] && gate && mod_ok;
        assign pwm_lo[g] = ch_lo[g] && gate && mod_ok;
    end

    assign aux_pwm = aux_q && gate;
endmodule

// File: rtl/pwm3_capcmp_chk.sv
module pwm3_capcmp_chk #(
    parameter int NCH    = 3,
    parameter int MAIN_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     trap_in,
    input logic                     trap_hold,
    input logic                     main_wrap,
    input logic                     main_load,
    input logic [NCH-1:0]           mode_q,
    input logic [NCH-1:0]           cap_fire,
    input logic [NCH-1:0][MAIN_W-1:0] cmp_act,
    input logic [NCH-1:0][MAIN_W-1:0] cap_val,
    input logic [NCH-1:0]           pwm_hi,
    input logic [NCH-1:0]           pwm_lo,
    input logic                     aux_pwm
);
    // R12
    trap_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_in |-> (pwm_hi == '0 && pwm_lo == '0 && !aux_pwm));

    // R12
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((trap_in || trap_hold) && !main_wrap) |=> (pwm_hi == '0 && pwm_lo == '0 && !aux_pwm));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R5
        pair_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pwm_hi[i] && pwm_lo[i]));

        // R5
        hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_hi[i]) |-> !$past(pwm_lo[i]));

        // R5
        lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_lo[i]) |-> !$past(pwm_hi[i]));

        // R6
        cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(main_wrap || main_load) |=> $stable(cmp_act[i]));

        // R8
        cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_fire[i] |=> $stable(cap_val[i]));

        // R9
        capmode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[i] && $past(mode_q[i])) |-> (!pwm_hi[i] && !pwm_lo[i]));
    end
endmodule

bind pwm3_capcmp pwm3_capcmp_chk #(.NCH(NCH), .MAIN_W(MAIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .trap_hold(trap_hold),
    .main_wrap(main_wrap), .main_load(main_load), .mode_q(mode_q),
    .cap_fire(cap_fire), .cmp_act(cmp_act), .cap_val(cap_val),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .aux_pwm(aux_pwm)
);

// File: tb/pwm3_capcmp_bench.sv
`timescale 1ns/1ps
module pwm3_capcmp_bench;
    import pwm3_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  cap_in = '0;
    logic        trap_in = 1'b0;
    logic [2:0]  pwm_hi, pwm_lo;
    logic        aux_pwm;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int hc[3], lc[3], mg[3], ov[3];
    int acnt;

    always #2.5 clk = ~clk;

    pwm3_capcmp u_pwm3_capcmp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .trap_in(trap_in), .pwm_hi(pwm_hi),
        .pwm_lo(pwm_lo), .aux_pwm(aux_pwm)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    function automatic int exp_hi(int D, int c, int P, int d);
        if (c == 0) return 0;
        if (c > P) return D * (P + 1);
        return D * c - (d + 1);
    endfunction

    function automatic int exp_lo(int D, int c, int P, int d);
        if (c == 0) return D * (P + 1);
        if (c > P) return 0;
        return D * (P + 1 - c) - (d + 1);
    endfunction

    task automatic measure(input int w);
        int gap[3];
        bit seen[3];
        for (int k = 0; k < 3; k++) begin
            hc[k] = 0; lc[k] = 0; ov[k] = 0; mg[k] = 1 << 20; gap[k] = 0; seen[k] = 0;
        end
        for (int n = 0; n < w; n++) begin
            @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                if (pwm_hi[k]) hc[k]++;
                if (pwm_lo[k]) lc[k]++;
                if (pwm_hi[k] && pwm_lo[k]) ov[k]++;
                if (!pwm_hi[k] && !pwm_lo[k]) gap[k]++;
                else begin
                    if (seen[k] && gap[k] > 0 && gap[k] < mg[k]) mg[k] = gap[k];
                    gap[k] = 0;
                    seen[k] = 1;
                end
            end
        end
    endtask

    task automatic measure_aux(input int w);
        acnt = 0;
        for (int n = 0; n < w; n++) begin
            @(negedge clk);
            if (aux_pwm) acnt++;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int v, v2, bad, seen;
        int dc, D, P, d, pa, ac_;
        int c[3];
        void'($urandom(32'd20240611));

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(pwm_hi == 0 && pwm_lo == 0 && !aux_pwm, "R1", "outputs in reset",
            int'({pwm_hi, pwm_lo, aux_pwm}), 0);
        rd(A_MPER, v); chk(v == 16'hFFFF, "R1", "main period default", v, 16'hFFFF);
        rd(A_DEAD, v); chk(v == 0, "R1", "dead default", v, 0);
        rd(A_CAP0, v); chk(v == 0, "R1", "capture default", v, 0);
        rst_n = 1'b1;
        #1;
        chk(pwm_hi == 0 && pwm_lo == 0 && !aux_pwm, "R1", "outputs after reset",
            int'({pwm_hi, pwm_lo, aux_pwm}), 0);

        // R2 register readback
        wr(A_DEAD, 8'h5A);            rd(A_DEAD, v); chk(v == 8'h5A, "R2", "dead readback", v, 8'h5A);
        wr(A_CMP0 + 4'd1, 16'h1234);  rd(A_CMP0 + 4'd1, v); chk(v == 16'h1234, "R2", "cmp1 readback", v, 16'h1234);
        wr(A_APER, 16'hFAAB);         rd(A_APER, v); chk(v == 16'h02AB, "R2", "aux period 10 bits", v, 16'h02AB);

        // R3 R4 R5 R10: random sweeps, iteration 0 carries compare edge cases
        for (int it = 0; it < 8; it++) begin
            dc = $urandom_range(0, 3);
            D = 1 << dc;
            P = $urandom_range(20, 60);
            d = $urandom_range(0, 6);
            pa = $urandom_range(10, 40);
            ac_ = $urandom_range(0, pa + 1);
            for (int k = 0; k < 3; k++) c[k] = $urandom_range(8, P - 8);
            if (it == 0) begin c[0] = 0; c[1] = P + 1; end
            wr(A_MODE, 0);
            wr(A_DEAD, d);
            wr(A_MPER, P);
            for (int k = 0; k < 3; k++) wr(A_CMP0 + 4'(k), c[k]);
            wr(A_APER, pa);
            wr(A_ACMP, ac_);
            wr(A_CTRL, (dc << 2) | 3);
            wr(A_MOFS, 0);
            wr(A_AOFS, 0);
            repeat (2 * D * (P + 1) + 40) @(negedge clk);
            measure(D * (P + 1));
            for (int k = 0; k < 3; k++) begin
                chk(hc[k] == exp_hi(D, c[k], P, d), "R4", "high-side on time", hc[k], exp_hi(D, c[k], P, d));
                chk(lc[k] == exp_lo(D, c[k], P, d), "R3", "low-side on time", lc[k], exp_lo(D, c[k], P, d));
                chk(ov[k] == 0, "R5", "pair overlap cycles", ov[k], 0);
                if (c[k] > 0 && c[k] <= P)
                    chk(mg[k] == d + 1, "R5", "dead gap length", mg[k], d + 1);
            end
            measure_aux(D * (pa + 1));
            v = D * ((ac_ > pa) ? pa + 1 : ac_);
            chk(acnt == v, "R10", "aux on time", acnt, v);
        end

        // R6 R7: halted timer, compare change waits for offset load
        wr(A_CTRL, 0);
        wr(A_DEAD, 0);
        wr(A_MPER, 99);
        wr(A_CMP0, 50);
        wr(A_MOFS, 10);
        repeat (20) @(negedge clk);
        chk(pwm_hi[0] == 1'b1, "R7", "hi after load below compare", int'(pwm_hi[0]), 1);
        wr(A_CMP0, 5);
        bad = 0;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            if (!pwm_hi[0]) bad++;
        end
        chk(bad == 0, "R6", "output held without wrap", bad, 0);
        wr(A_MOFS, 10);
        repeat (10) @(negedge clk);
        chk(!pwm_hi[0] && pwm_lo[0], "R6", "new compare after load",
            int'({pwm_hi[0], pwm_lo[0]}), 1);

        // R9 capture mode silences outputs
        wr(A_CTRL, 1);
        wr(A_MODE, 3'b111);
        repeat (4) @(negedge clk);
        bad = 0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (pwm_hi != 0 || pwm_lo != 0) bad++;
        end
        chk(bad == 0, "R9", "outputs in capture mode", bad, 0);

        // R8 R7 capture with halted timer at a loaded count
        wr(A_CTRL, 0);
        wr(A_MODE, 3'b001);
        wr(A_MOFS, 1234);
        @(negedge clk); cap_in[0] = 1'b1; cap_in[1] = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_CAP0, v);        chk(v == 1234, "R8", "capture of loaded count", v, 1234);
        rd(A_CAP0 + 4'd1, v); chk(v == 0, "R8", "compare-mode pin ignored", v, 0);

        // R8 capture spacing with running timer, both edge directions
        wr(A_MODE, 3'b101);
        wr(A_MPER, 16'hFFFF);
        wr(A_CTRL, 1);
        wr(A_MOFS, 0);
        @(negedge clk); cap_in[0] = 1'b0;
        repeat (300) @(negedge clk);
        cap_in[2] = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_CAP0, v); rd(A_CAP0 + 4'd2, v2);
        chk(v2 - v == 300, "R8", "capture spacing", v2 - v, 300);

        // R11 modulation by aux output
        wr(A_MODE, 0);
        wr(A_DEAD, 1);
        wr(A_MPER, 39);
        for (int k = 0; k < 3; k++) wr(A_CMP0 + 4'(k), 20);
        wr(A_APER, 9);
        wr(A_ACMP, 0);
        wr(A_CTRL, 5'b10011);
        wr(A_MOFS, 0);
        wr(A_AOFS, 0);
        repeat (100) @(negedge clk);
        measure(40);
        chk(hc[0] + lc[0] + hc[1] + lc[1] + hc[2] + lc[2] == 0, "R11", "gated by low aux",
            hc[0] + lc[0] + hc[1] + lc[1] + hc[2] + lc[2], 0);
        wr(A_ACMP, 11);
        wr(A_AOFS, 0);
        repeat (100) @(negedge clk);
        measure(40);
        chk(hc[1] == 18 && lc[1] == 18, "R11", "pass with high aux", hc[1] + lc[1], 36);

        // R12 trap
        wr(A_CTRL, 3);
        wr(A_DEAD, 2);
        wr(A_MPER, 99);
        for (int k = 0; k < 3; k++) wr(A_CMP0 + 4'(k), 50);
        wr(A_ACMP, 5);
        wr(A_MOFS, 0);
        wr(A_AOFS, 0);
        repeat (250) @(negedge clk);
        trap_in = 1'b1;
        #1;
        chk(pwm_hi == 0 && pwm_lo == 0 && !aux_pwm, "R12", "trap immediate",
            int'({pwm_hi, pwm_lo, aux_pwm}), 0);
        wr(A_MOFS, 0);
        trap_in = 1'b0;
        bad = 0;
        for (int n = 0; n < 50; n++) begin
            @(negedge clk);
            if (pwm_hi != 0 || pwm_lo != 0 || aux_pwm) bad++;
        end
        chk(bad == 0, "R12", "held low before wrap", bad, 0);
        seen = 0;
        for (int n = 0; n < 150; n++) begin
            @(negedge clk);
            if (pwm_hi != 0 || pwm_lo != 0) seen = 1;
        end
        chk(seen == 1, "R12", "resume after wrap", seen, 1);

        finish_run();
    end
endmodule